// File: doc/BRIEF.md
# Branch Target Fault Checker

This block watches two points of a 64-bit pipeline that uses 39-bit virtual addresses. At the resolve point it looks at each taken branch or jump. If the computed target is not on a 4-byte boundary, it raises an instruction-address-misaligned exception. That exception is charged to the branch itself: the report carries the branch PC as the exception PC and the target as the trap value.

At the fetch point it looks at each fetch request. If the fetched address is not canonical, it raises an instruction page fault against that fetch, with the address as the trap value. A non-canonical address has bits above bit 38 that do not all copy bit 38.

Each report comes from a register and lasts one cycle. A flush input cancels any report that its cycle would have produced. The two reporting points are independent, so both can report in the same cycle. Misaligned, access-fault and page-fault conditions each have their own cause code. This block only ever emits the misaligned code and the page-fault code.

Top module: `branch_target_fault_chk`

## Requirements
- R1: A fetch request (`fe_valid`=1) is faulted when its address is 4-byte aligned and non-canonical, meaning bits 63..39 are not all equal to bit 38. The fault appears on the next cycle as `fe_exc_valid`=1, with `fe_exc_cause`=12 and `fe_exc_tval` equal to the address.
- R2: A taken branch (`rs_taken`=1) is faulted when bits 1..0 of its target are not both zero. The fault appears on the next cycle as `rs_exc_valid`=1, with `rs_exc_cause`=0, `rs_exc_tval` equal to the target and `rs_exc_epc` equal to the branch PC.
- R3: A branch with `rs_taken`=0 never produces a resolve-stage exception, whatever its target.
- R4: A non-canonical but aligned target on a taken branch produces no resolve-stage exception. Its page fault is raised only when that address is presented for fetch.
- R5: A target that is both misaligned and non-canonical yields only the misaligned exception (cause 0) at resolve. Fetching such an address yields no page fault.
- R6: Each exception output is high for exactly the one cycle after the offending input cycle. Back-to-back offending inputs give back-to-back one-cycle reports. In any cycle without a report, the cause, tval and epc outputs read zero.
- R7: When `flush`=1 in an input cycle, neither stage reports an exception in the following cycle.
- R8: During and directly after a synchronous active-low reset, all outputs are zero.
- R9: The two stages are independent. A resolve-stage misalignment and a fetch-stage page fault from the same input cycle are both reported in the following cycle, each with its own cause and tval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Cancels reports from the current input cycle |
| rs_taken | input | 1 | Branch at the resolve point is taken |
| rs_pc | input | 64 | PC of the resolving branch |
| rs_target | input | 64 | Computed branch target |
| fe_valid | input | 1 | Fetch request valid |
| fe_addr | input | 64 | Fetch address |
| rs_exc_valid | output | 1 | Misaligned-target exception report |
| rs_exc_cause | output | 5 | Cause code (0) |
| rs_exc_tval | output | 64 | Offending target |
| rs_exc_epc | output | 64 | PC of the branch charged with the exception |
| fe_exc_valid | output | 1 | Instruction page fault report |
| fe_exc_cause | output | 5 | Cause code (12) |
| fe_exc_tval | output | 64 | Faulting fetch address |

## Verification
The resolve-stage misaligned check and the fetch-stage page-fault check can both fire in the same cycle. The bench provokes this on purpose by driving a misaligned taken branch and a non-canonical aligned fetch together. It also mixes the two stages freely in random traffic. Each output set is judged separately against its own expected values, so a cross-wired cause or tval shows up. A directed case drives the same misaligned, non-canonical address into both stages at once and expects only the cause-0 report.

// File: rtl/bte_pkg.sv
// Package: shared widths and cause codes for the branch target fault checker.
// Assumes a 64-bit datapath with 39-bit virtual addressing and 4-byte instructions.
package bte_pkg;
    parameter int XLEN       = 64;
    parameter int VA_BITS    = 39;
    parameter int ALIGN_BITS = 2;
    parameter int CAUSE_W    = 5;

    // Instruction fault kinds, each with its own code
    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IMISALIGN = 5'd0,
        CAUSE_IACCESS   = 5'd1,
        CAUSE_IPAGE     = 5'd12
    } icause_e;
endpackage

// File: rtl/va_canon_chk.sv
// Module: va_canon_chk
// Reports whether an address is canonical: every bit above VA_BITS-1 equals bit VA_BITS-1.
// Assumes VA_BITS <= XLEN; when they are equal every address is canonical.
module va_canon_chk #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 39
) (
    input  logic [XLEN-1:0] addr,
    output logic            canonical
);
    localparam int UPPER_W = XLEN - VA_BITS + 1;

    generate
        if (VA_BITS >= XLEN) begin : g_full
            // Purpose: the whole register is address, nothing to compare
            always_comb canonical = 1'b1;
        end else begin : g_ext
            logic [UPPER_W-1:0] upper;
            // Purpose: the sign bit plus all bits above it must be uniform
            always_comb begin
                upper     = addr[XLEN-1:VA_BITS-1];
                canonical = (upper == '0) || (upper == '1);
            end
        end
    endgenerate
endmodule

// File: rtl/ialign_chk.sv
// Module: ialign_chk
// Flags an instruction address that is not on a 2**ALIGN_BITS byte boundary.
// Assumes ALIGN_BITS of 0 means any byte address is allowed.
module ialign_chk #(
    parameter int XLEN       = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic [XLEN-1:0] addr,
    output logic            misaligned
);
    generate
        if (ALIGN_BITS == 0) begin : g_any
            // Purpose: no alignment rule applies
            always_comb misaligned = 1'b0;
        end else begin : g_rule
            // Purpose: any set bit below the boundary is a misalignment
            always_comb misaligned = |addr[ALIGN_BITS-1:0];
        end
    endgenerate
endmodule

// File: rtl/exc_slot.sv
// Module: exc_slot
// One registered exception report: a one-cycle valid pulse with cause, tval and epc.
// Assumes 'set' is a single-cycle request. Flush in the request cycle cancels it.
// Fields read zero when no report is valid.
module exc_slot #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               set,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic [XLEN-1:0]    tval_in,
    input  logic [XLEN-1:0]    epc_in,
    output logic               valid,
    output logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    tval,
    output logic [XLEN-1:0]    epc
);
    logic fire;

    // Purpose: a request survives only if no flush arrives with it
    always_comb fire = set && !flush;

    // Purpose: capture the report for exactly one cycle, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            cause <= '0;
            tval  <= '0;
            epc   <= '0;
        end else if (fire) begin
            valid <= 1'b1;
            cause <= cause_in;
            tval  <= tval_in;
            epc   <= epc_in;
        end else begin
            valid <= 1'b0;
            cause <= '0;
            tval  <= '0;
            epc   <= '0;
        end
    end

    AST_SLOT_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !flush) |=> (valid && tval == $past(tval_in))); // R6
    AST_SLOT_FLUSH_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid); // R7
    AST_SLOT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (cause == '0 && tval == '0 && epc == '0)); // R6
endmodule

// File: rtl/branch_target_fault_chk.sv
// Module: branch_target_fault_chk (top)
// Checks taken-branch targets for misalignment at resolve, charged to the branch,
// and fetch addresses for non-canonical form at fetch, reported as a page fault.
// Assumes one resolving branch and one fetch request per cycle at most.
module branch_target_fault_chk
    import bte_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               rs_taken,
    input  logic [XLEN-1:0]    rs_pc,
    input  logic [XLEN-1:0]    rs_target,
    input  logic               fe_valid,
    input  logic [XLEN-1:0]    fe_addr,
    output logic               rs_exc_valid,
    output logic [CAUSE_W-1:0] rs_exc_cause,
    output logic [XLEN-1:0]    rs_exc_tval,
    output logic [XLEN-1:0]    rs_exc_epc,
    output logic               fe_exc_valid,
    output logic [CAUSE_W-1:0] fe_exc_cause,
    output logic [XLEN-1:0]    fe_exc_tval
);
    localparam int SIGN_BIT = VA_BITS - 1;

    logic rs_mis;
    logic fe_mis;
    logic fe_canon;
    logic rs_set;
    logic fe_set;
    logic [XLEN-1:0] fe_epc_unused;

    ialign_chk #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_rs_align (
        .addr       (rs_target),
        .misaligned (rs_mis)
    );

    ialign_chk #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_fe_align (
        .addr       (fe_addr),
        .misaligned (fe_mis)
    );

    va_canon_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_fe_canon (
        .addr      (fe_addr),
        .canonical (fe_canon)
    );

    // Purpose: resolve-stage request; canonical form is deliberately not checked here
    always_comb rs_set = rs_taken && rs_mis;

    // Purpose: fetch-stage request; a misaligned address already trapped at resolve
    always_comb fe_set = fe_valid && !fe_canon && !fe_mis;

    exc_slot #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_rs_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .set      (rs_set),
        .cause_in (CAUSE_IMISALIGN),
        .tval_in  (rs_target),
        .epc_in   (rs_pc),
        .valid    (rs_exc_valid),
        .cause    (rs_exc_cause),
        .tval     (rs_exc_tval),
        .epc      (rs_exc_epc)
    );

    exc_slot #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_fe_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .set      (fe_set),
        .cause_in (CAUSE_IPAGE),
        .tval_in  (fe_addr),
        .epc_in   (fe_addr),
        .valid    (fe_exc_valid),
        .cause    (fe_exc_cause),
        .tval     (fe_exc_tval),
        .epc      (fe_epc_unused)
    );

    AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_taken |=> !rs_exc_valid); // R3
    AST_RS_ONLY_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rs_exc_valid |-> (rs_exc_cause == CAUSE_IMISALIGN && rs_exc_tval[1:0] != 2'b00)); // R2
    AST_FE_NONCANON: assert property (@(posedge clk) disable iff (!rst_n)
        fe_exc_valid |-> (fe_exc_cause == CAUSE_IPAGE &&
                          fe_exc_tval[XLEN-1:SIGN_BIT] != '0 &&
                          fe_exc_tval[XLEN-1:SIGN_BIT] != '1)); // R1
    AST_FE_ALIGNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fe_exc_valid |-> (fe_exc_tval[1:0] == 2'b00)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rs_exc_valid && !fe_exc_valid)); // R8
endmodule

// File: tb/branch_target_fault_chk_tb.sv
module branch_target_fault_chk_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        rs_taken;
    logic [63:0] rs_pc;
    logic [63:0] rs_target;
    logic        fe_valid;
    logic [63:0] fe_addr;
    logic        rs_exc_valid;
    logic [4:0]  rs_exc_cause;
    logic [63:0] rs_exc_tval;
    logic [63:0] rs_exc_epc;
    logic        fe_exc_valid;
    logic [4:0]  fe_exc_cause;
    logic [63:0] fe_exc_tval;

    int  n_vec  = 0;
    int  n_miss = 0;
    bit  done   = 0;
    int  seed   = 32'h5eed_b7e1;

    always #2 clk = ~clk;

    branch_target_fault_chk u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .rs_taken(rs_taken), .rs_pc(rs_pc), .rs_target(rs_target),
        .fe_valid(fe_valid), .fe_addr(fe_addr),
        .rs_exc_valid(rs_exc_valid), .rs_exc_cause(rs_exc_cause),
        .rs_exc_tval(rs_exc_tval), .rs_exc_epc(rs_exc_epc),
        .fe_exc_valid(fe_exc_valid), .fe_exc_cause(fe_exc_cause),
        .fe_exc_tval(fe_exc_tval)
    );

    function automatic bit noncanon(input logic [63:0] a);
        return !((a[63:38] == '0) || (a[63:38] == '1));
    endfunction

    function automatic bit misal(input logic [63:0] a);
        return a[1:0] != 2'b00;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one input cycle, then check the registered outputs a cycle later
    task automatic step(input string req, input bit fl, input bit tk,
                        input logic [63:0] pc, input logic [63:0] tg,
                        input bit fv, input logic [63:0] fa);
        bit exp_rs;
        bit exp_fe;
        flush = fl; rs_taken = tk; rs_pc = pc; rs_target = tg;
        fe_valid = fv; fe_addr = fa;
        exp_rs = tk && misal(tg) && !fl;                      // R2 R3 R7
        exp_fe = fv && noncanon(fa) && !misal(fa) && !fl;     // R1 R5 R7
        @(posedge clk);
        @(negedge clk);
        chk(req, "rs_valid", {63'd0, rs_exc_valid}, {63'd0, exp_rs});
        chk(req, "rs_cause", {59'd0, rs_exc_cause}, 64'd0);
        chk(req, "rs_tval",  rs_exc_tval, exp_rs ? tg : 64'd0);
        chk(req, "rs_epc",   rs_exc_epc,  exp_rs ? pc : 64'd0);
        chk(req, "fe_valid", {63'd0, fe_exc_valid}, {63'd0, exp_fe});
        chk(req, "fe_cause", {59'd0, fe_exc_cause}, exp_fe ? 64'd12 : 64'd0);
        chk(req, "fe_tval",  fe_exc_tval, exp_fe ? fa : 64'd0);
    endtask

    function automatic logic [63:0] rnd_addr();
        logic [63:0] a;
        int unsigned m;
        a = {$urandom, $urandom};
        m = $urandom % 4;
        case (m)
            0: a[63:38] = '0;
            1: a[63:38] = '1;
            2: a[63:38] = {25'h0, 1'b1} ^ (($urandom % 2) ? '1 : '0);
            default: ;
        endcase
        if ($urandom % 3 != 0) a[1:0] = 2'b00;
        return a;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        void'($urandom(seed));
        rst_n = 1'b0; flush = 0; rs_taken = 0; rs_pc = '0; rs_target = '0;
        fe_valid = 0; fe_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: outputs clear in reset
        chk("R8", "rs_valid", {63'd0, rs_exc_valid}, 64'd0);
        chk("R8", "fe_valid", {63'd0, fe_exc_valid}, 64'd0);
        chk("R8", "rs_tval", rs_exc_tval, 64'd0);
        chk("R8", "fe_tval", fe_exc_tval, 64'd0);
        rst_n = 1'b1;

        // R2 misaligned taken target, charged to branch PC
        step("R2", 0, 1, 64'h1000, 64'h2002, 0, '0);
        // R3 not-taken misaligned target
        step("R3", 0, 0, 64'h1004, 64'h2003, 0, '0);
        // R4 non-canonical aligned target: nothing at resolve
        step("R4", 0, 1, 64'h1008, 64'h0000_0040_0000_0000, 0, '0);
        // R4/R1 then fetching it raises the page fault
        step("R1", 0, 0, '0, '0, 1, 64'h0000_0040_0000_0000);
        // R1 boundary addresses
        step("R1", 0, 0, '0, '0, 1, 64'h0000_003F_FFFF_FFFC);
        step("R1", 0, 0, '0, '0, 1, 64'hFFFF_FFC0_0000_0000);
        step("R1", 0, 0, '0, '0, 1, 64'hFFFF_FF80_0000_0000);
        step("R1", 0, 0, '0, '0, 1, 64'h8000_0000_0000_0000);
        // R5 both misaligned and non-canonical in both stages
        step("R5", 0, 1, 64'h100C, 64'h0000_0040_0000_0001, 1, 64'h0000_0040_0000_0001);
        // R6 back-to-back reports then an idle cycle
        step("R6", 0, 1, 64'h2000, 64'h3001, 0, '0);
        step("R6", 0, 1, 64'h2004, 64'h3006, 0, '0);
        step("R6", 0, 0, '0, '0, 0, '0);
        // R7 flush cancels both stages
        step("R7", 1, 1, 64'h2008, 64'h3003, 1, 64'h0000_0100_0000_0000);
        // R9 both stages in the same cycle
        step("R9", 0, 1, 64'h200C, 64'h4002, 1, 64'hF000_0000_0000_0000);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] t;
            bit both;
            t = rnd_addr();
            both = ($urandom % 8 == 0);
            step("R9", ($urandom % 16 == 0), $urandom % 2, {$urandom, $urandom}, t,
                 $urandom % 2, both ? t : rnd_addr());
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule